// File: doc/BRIEF.md
# Load-or-Accumulate Register

This block is a clocked running-sum register. On every rising clock edge it either restarts its total at the value on the data input or adds that input to the total it already holds. A single load control picks between the two cases, one cycle at a time. The output is the stored total, so it is a plain register output that moves only at clock edges.

Inside, a mux feeds the adder its second operand. The operand is zero when a restart is wanted and the current total otherwise, so one adder serves both cases and its result is always the next state. A synchronous, active-high reset clears the total to zero. Sums wrap silently at the word width. The word width is a parameter. A second parameter picks how the adder is built: a behavioural `+` operator, or an explicit bit-by-bit carry chain made with generate.

Typical use is to collect a stream of samples into groups. The stream is presented one word per cycle, and load is pulsed on the first word of each group.

Top module: `sum_restart_acc`

## Requirements
- R1: While `rst` is 1 at a rising edge, `acc_o` becomes 0 after that edge, whatever `load_i` and `din_i` are. Reset wins over load.
- R2: At a rising edge with `rst`=0 and `load_i`=1, `acc_o` becomes the value `din_i` had at that edge.
- R3: At a rising edge with `rst`=0 and `load_i`=0, `acc_o` becomes its old value plus the value `din_i` had at that edge.
- R4: The sum in R3 is taken modulo 2^WIDTH. A carry out of the top bit is dropped and nothing reports it.
- R5: `acc_o` changes only at rising clock edges. Changes on `din_i` or `load_i` between edges do not show on `acc_o`.
- R6: A load may come in any cycle and restarts the total each time. With load at the 1st and 4th of six inputs x0..x5, the output after each edge is x0, x0+x1, x0+x1+x2, x3, x3+x4, x3+x4+x5.
- R7: Both adder builds (ADD_IMPL=0 behavioural, ADD_IMPL=1 ripple carry chain) give identical results for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears the total |
| load_i | input | 1 | 1: restart the total at din_i; 0: add din_i to the total |
| din_i | input | WIDTH | Input word |
| acc_o | output | WIDTH | Current stored total |

## Verification
The six-step example with two loads checks that the total restarts where it should and accumulates in between. A stream of about three hundred pseudo-random words with random load pulses is compared with a behavioural model on every clock, with both adder builds running side by side. This separates a wrong operand choice from a wrong carry path. Sums that cross 2^WIDTH confirm the wraparound, a reset applied together with load confirms that reset wins, and input changes in the middle of a cycle confirm that the output holds between edges.

// File: rtl/sum_acc_pkg.sv
package sum_acc_pkg;
   // How the adder is built
   localparam int ADD_BEHAV = 0;
   localparam int ADD_RIPPLE = 1;
   localparam int ADD_IMPL_MAX = 1;
   localparam int WIDTH_MAX = 1024;
endpackage

// File: rtl/sum_acc_addend_mux.sv
// Second adder operand: zero when restarting, otherwise the stored total.
module sum_acc_addend_mux #(
   parameter int WIDTH = 16
) (
   input  logic             zero_sel_i,
   input  logic [WIDTH-1:0] state_i,
   output logic [WIDTH-1:0] addend_o
);
   localparam logic [WIDTH-1:0] ZERO_W = '0;

   always_comb begin
      if (zero_sel_i) addend_o = ZERO_W;
      else            addend_o = state_i;
   end
endmodule

// File: rtl/sum_acc_adder.sv
// Wrapping adder; ADD_IMPL picks a behavioural or an explicit ripple build.
module sum_acc_adder
   import sum_acc_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter int ADD_IMPL = ADD_BEHAV
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] sum_o
);
   initial begin
      assert (ADD_IMPL >= 0 && ADD_IMPL <= ADD_IMPL_MAX)
         else $error("sum_acc_adder: ADD_IMPL out of range");
   end

   generate
      if (ADD_IMPL == ADD_RIPPLE) begin : g_ripple
         logic [WIDTH:0] carry;
         assign carry[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_o[i]    = a_i[i] ^ b_i[i] ^ carry[i];
            assign carry[i+1]  = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
         end
         // Carry chain agrees with the arithmetic sum, truncated
         AST_RIPPLE_MATCH: assert property (@(posedge clk) disable iff (rst)
            sum_o == WIDTH'(a_i + b_i));  // R7
      end else begin : g_behav
         logic [WIDTH:0] full_sum;
         assign full_sum = {1'b0, a_i} + {1'b0, b_i};
         assign sum_o    = full_sum[WIDTH-1:0];
      end
   endgenerate
endmodule

// File: rtl/sum_acc_state_reg.sv
// Holding register with synchronous clear.
module sum_acc_state_reg #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] next_i,
   output logic [WIDTH-1:0] q_o
);
   localparam logic [WIDTH-1:0] CLEAR_W = '0;

   always_ff @(posedge clk) begin
      if (rst) q_o <= CLEAR_W;
      else     q_o <= next_i;
   end

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> q_o == CLEAR_W);  // R1
endmodule

// File: rtl/sum_restart_acc.sv
module sum_restart_acc
   import sum_acc_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter int ADD_IMPL = ADD_BEHAV
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [WIDTH-1:0] din_i,
   output logic [WIDTH-1:0] acc_o
);
   initial begin
      assert (WIDTH >= 1 && WIDTH <= WIDTH_MAX)
         else $error("sum_restart_acc: WIDTH out of range");
   end

   logic [WIDTH-1:0] addend;
   logic [WIDTH-1:0] next_sum;

   sum_acc_addend_mux #(.WIDTH(WIDTH)) u_mux (
      .zero_sel_i (load_i),
      .state_i    (acc_o),
      .addend_o   (addend)
   );

   sum_acc_adder #(.WIDTH(WIDTH), .ADD_IMPL(ADD_IMPL)) u_add (
      .clk   (clk),
      .rst   (rst),
      .a_i   (din_i),
      .b_i   (addend),
      .sum_o (next_sum)
   );

   sum_acc_state_reg #(.WIDTH(WIDTH)) u_reg (
      .clk    (clk),
      .rst    (rst),
      .next_i (next_sum),
      .q_o    (acc_o)
   );

   AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
      load_i |=> acc_o == $past(din_i));  // R2
   AST_ACCUM_WRAP: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> acc_o == WIDTH'($past(acc_o) + $past(din_i)));  // R3
endmodule

// File: tb/tb_sum_restart_acc.sv
`timescale 1ns/1ps
module tb_sum_restart_acc;
   localparam int W = 16;
   localparam int HALF = 2;  // 250 MHz

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         load = 1'b0;
   logic [W-1:0] din = '0;
   logic [W-1:0] acc_b, acc_r;

   int errors = 0;
   int checks = 0;
   logic [W-1:0] model = '0;
   bit done = 0;

   always #HALF clk = ~clk;

   sum_restart_acc #(.WIDTH(W), .ADD_IMPL(0)) dut (
      .clk(clk), .rst(rst), .load_i(load), .din_i(din), .acc_o(acc_b));
   sum_restart_acc #(.WIDTH(W), .ADD_IMPL(1)) dut_rip (
      .clk(clk), .rst(rst), .load_i(load), .din_i(din), .acc_o(acc_r));

   task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: acc=%h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // One clock: drive at negedge, update model at posedge, sample 1 ns later
   task automatic step(input logic r, input logic ld, input logic [W-1:0] d, input string req);
      @(negedge clk);
      rst = r; load = ld; din = d;
      @(posedge clk);
      if (r)       model = '0;
      else if (ld) model = d;
      else         model = W'(model + d);
      #1;
      check(req, acc_b, model);
      check({req, "/R7"}, acc_r, model);
   endtask

   initial begin
      #(4 * HALF * 5000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run hung");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      // R1: reset state, and reset wins over load
      step(1'b1, 1'b1, 16'h1234, "R1");
      step(1'b1, 1'b0, 16'h0000, "R1");

      // R6: example sequence with loads on x0 and x3
      step(1'b0, 1'b1, 16'd5,   "R6");   // 5
      step(1'b0, 1'b0, 16'd7,   "R6");   // 12
      step(1'b0, 1'b0, 16'd11,  "R6");   // 23
      step(1'b0, 1'b1, 16'd100, "R6");   // 100
      step(1'b0, 1'b0, 16'd3,   "R6");   // 103
      step(1'b0, 1'b0, 16'd9,   "R6");   // 112
      checks++;
      if (acc_b !== 16'd112) begin
         errors++;
         $display("FAIL R6: acc=%0d expected 112", acc_b);
      end

      // R5: change inputs mid-cycle, output must hold
      @(negedge clk);
      load = 1'b1; din = 16'hBEEF;
      #1;
      check("R5", acc_b, 16'd112);
      din = 16'h0F0F; load = 1'b0;
      #0.5;
      check("R5", acc_b, 16'd112);

      // R2: load of zero and of all-ones
      step(1'b0, 1'b1, 16'h0000, "R2");
      step(1'b0, 1'b1, 16'hFFFF, "R2");
      // R4: wraparound
      step(1'b0, 1'b0, 16'h0001, "R4");  // 0x0000
      step(1'b0, 1'b1, 16'hFFF0, "R2");
      step(1'b0, 1'b0, 16'h0025, "R4");  // 0x0015
      check("R4", acc_b, 16'h0015);
      // R3: plain accumulation of zero leaves total
      step(1'b0, 1'b0, 16'h0000, "R3");

      // R1: reset in the middle of a run
      step(1'b1, 1'b0, 16'h7777, "R1");
      step(1'b0, 1'b0, 16'h0042, "R3");

      // R3/R2/R7: pseudo-random stream with random loads
      lfsr = 16'hACE1;
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(1'b0, (lfsr[3:0] == 4'h0), lfsr ^ 16'h5A5A, "R3");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule